// File: doc/BRIEF.md
# Receive Frame Splitter for a Serial Storage Host

This block sits between the link layer of a serial storage host and the command sequencer. It accepts frame information structures (FISes) one 32-bit word per cycle on an active-low framed interface (start, end and valid strobes). On the first word it reads the type byte. If the frame is a data frame, the header word is discarded and the payload words go to one of two sinks. During a read command they go to the user receive FIFO. During an identify command they go to a 128-entry identify port that carries a word index. Every other frame is passed word by word to the sequencer, which decides whether the status is normal or an error.

Backpressure comes from the receive FIFO's 16-bit fill counter rather than from a full flag. When the counter's top thirteen bits are all ones, the ready output is withdrawn. The FIFO's 8-word margin then absorbs the short stop latency. The block also raises a one-cycle error strobe for a data frame that it cannot route. The legality of the frame sequence is checked elsewhere.

Top module: `fis_rx_split`

## Requirements
- R1: The local disconnect output `rx_dsc_n` is always 1. After reset, `fifo_we`, `id_we`, `ctl_vld` and `hdr_err` are 0.
- R2: `rx_rdy_n` is 1 exactly when `mode_read` is 1 and `fifo_cnt[15:3]` are all ones, that is `fifo_cnt` >= 65528. Otherwise it is 0.
- R3: A word is accepted when `rx_vld_n` and `rx_rdy_n` are both 0. A frame whose first word has bits [7:0] = 8'h46 and bits [31:8] = 0 is a data frame. With `mode_read` = 1 and `mode_ident` = 0, each accepted payload word after the header is written to the FIFO on `fifo_we`/`fifo_wd` one cycle after acceptance, in order. The header word is never written.
- R4: Once `fifo_cnt` >= 65528 during a read, no FIFO write occurs from the next cycle onward, which is well inside the 7-cycle limit. A word offered while ready is withdrawn is not taken.
- R5: During an identify (`mode_ident` = 1), data-frame payload goes to `id_we`/`id_wd` one cycle after acceptance and never to the FIFO. Identify takes priority when both modes are set.
- R6: `id_idx` is 0 for the first payload word of every identify data frame and increases by 1 for each accepted word, reaching 127 on the 128th word.
- R7: A frame whose first byte is not 8'h46 is forwarded whole on `ctl_vld`/`ctl_data` one cycle after each accepted word. `ctl_first` marks the first word and `ctl_last` marks the word that carried the end strobe.
- R8: If a data-frame header has nonzero bits [31:8], or arrives with neither mode set, `hdr_err` pulses for one cycle after the header. The payload of that frame reaches no sink.
- R9: Words with `rx_vld_n` = 1 are ignored. So are words that follow a frame's end before the next start strobe. Neither produces any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_read | input | 1 | Read command active |
| mode_ident | input | 1 | Identify command active |
| rx_data | input | 32 | Receive word from the link layer |
| rx_sof_n | input | 1 | Start of frame, active low |
| rx_eof_n | input | 1 | End of frame, active low |
| rx_vld_n | input | 1 | Word valid, active low |
| rx_rdy_n | output | 1 | Ready to accept, active low |
| rx_dsc_n | output | 1 | Local disconnect, held at 1 |
| fifo_cnt | input | 16 | Receive FIFO fill counter |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_wd | output | 32 | Receive FIFO write word |
| id_we | output | 1 | Identify port write strobe |
| id_idx | output | 7 | Identify word index |
| id_wd | output | 32 | Identify word |
| ctl_vld | output | 1 | Non-data frame word valid to the sequencer |
| ctl_first | output | 1 | First word of a non-data frame |
| ctl_last | output | 1 | Last word of a non-data frame |
| ctl_data | output | 32 | Non-data frame word |
| hdr_err | output | 1 | Data frame header error strobe |

## Verification
`rx_rdy_n` is combinational in `mode_read` and `fifo_cnt`, so the bench checks it one time step after changing the counter, with no clock edge in between. Every other result comes from one register stage. The bench drives each word on a falling edge and reads the outputs on the next falling edge, after the single rising edge that registers the word. A refused word is checked at that same point for the absence of a write, and is then offered again. The sweeps cover payload lengths of 1 to 8 and 128 words, and every counter value from 65500 to 65535.

// File: rtl/fis_rx_split.sv
module fis_rx_split #(
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int IW = 7,
  parameter int MARGIN_LOG2 = 3,
  parameter logic [7:0] DATA_CODE = 8'h46
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_read,
  input  logic          mode_ident,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_sof_n,
  input  logic          rx_eof_n,
  input  logic          rx_vld_n,
  output logic          rx_rdy_n,
  output logic          rx_dsc_n,
  input  logic [CW-1:0] fifo_cnt,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_wd,
  output logic          id_we,
  output logic [IW-1:0] id_idx,
  output logic [DW-1:0] id_wd,
  output logic          ctl_vld,
  output logic          ctl_first,
  output logic          ctl_last,
  output logic [DW-1:0] ctl_data,
  output logic          hdr_err
);
  typedef enum logic [1:0] {K_IDLE, K_RD, K_ID, K_CTL} kind_t;

  kind_t         kind_q, kind_new;
  logic [IW-1:0] idx_q;

  wire near_full = &fifo_cnt[CW-1:MARGIN_LOG2];
  assign rx_rdy_n = mode_read & near_full;
  assign rx_dsc_n = 1'b1;

  wire take   = !rx_vld_n && !rx_rdy_n;
  wire first  = take && !rx_sof_n;
  wire last   = !rx_eof_n;
  wire is_dat = rx_data[7:0] == DATA_CODE;
  wire hdr_ok = rx_data[DW-1:8] == '0;

  always_comb begin
    if (!is_dat)         kind_new = K_CTL;
    else if (!hdr_ok)    kind_new = K_IDLE;
    else if (mode_ident) kind_new = K_ID;
    else if (mode_read)  kind_new = K_RD;
    else                 kind_new = K_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q    <= K_IDLE;
      idx_q     <= '0;
      fifo_we   <= 1'b0;
      fifo_wd   <= '0;
      id_we     <= 1'b0;
      id_idx    <= '0;
      id_wd     <= '0;
      ctl_vld   <= 1'b0;
      ctl_first <= 1'b0;
      ctl_last  <= 1'b0;
      ctl_data  <= '0;
      hdr_err   <= 1'b0;
    end else begin
      fifo_we <= 1'b0;
      id_we   <= 1'b0;
      ctl_vld <= 1'b0;
      hdr_err <= first && is_dat && (kind_new == K_IDLE);
      if (first) begin
        kind_q <= last ? K_IDLE : kind_new;
        idx_q  <= '0;
        if (kind_new == K_CTL) begin
          ctl_vld   <= 1'b1;
          ctl_first <= 1'b1;
          ctl_last  <= last;
          ctl_data  <= rx_data;
        end
      end else if (take) begin
        case (kind_q)
          K_RD: begin
            fifo_we <= 1'b1;
            fifo_wd <= rx_data;
          end
          K_ID: begin
            id_we  <= 1'b1;
            id_idx <= idx_q;
            id_wd  <= rx_data;
            idx_q  <= idx_q + 1'b1;
          end
          K_CTL: begin
            ctl_vld   <= 1'b1;
            ctl_first <= 1'b0;
            ctl_last  <= last;
            ctl_data  <= rx_data;
          end
          default: ;
        endcase
        if (last) kind_q <= K_IDLE;
      end
    end
  end
endmodule

// File: rtl/fis_rx_split_chk.sv
module fis_rx_split_chk #(
  parameter int CW = 16,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_read,
  input logic          rx_sof_n,
  input logic          rx_vld_n,
  input logic          rx_rdy_n,
  input logic          rx_dsc_n,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_we,
  input logic          id_we,
  input logic [IW-1:0] id_idx,
  input logic          ctl_vld,
  input logic          ctl_first,
  input logic          hdr_err
);
  a_r1_dsc_held: assert property (@(posedge clk) rx_dsc_n);

  a_r3_write_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(!rx_vld_n && !rx_rdy_n && rx_sof_n));

  a_r4_stop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_read && (&fifo_cnt[CW-1:3])) |-> !fifo_we);

  a_r5_one_sink: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_we, id_we, ctl_vld}));

  a_r6_idx_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (id_we && $past(!rx_sof_n && !rx_vld_n && !rx_rdy_n, 2)
           && $past(rx_sof_n && !rx_vld_n && !rx_rdy_n)) |-> id_idx == '0);

  a_r7_ctl_first_follows_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_vld && ctl_first) |-> $past(!rx_sof_n && !rx_vld_n));

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !fifo_we && !id_we && !ctl_vld);
endmodule

bind fis_rx_split fis_rx_split_chk #(.CW(CW), .IW(IW)) u_chk (.*);

// File: tb/sim_fis_rx_split.sv
module sim_fis_rx_split;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_read = 1'b0, mode_ident = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_sof_n = 1'b1, rx_eof_n = 1'b1, rx_vld_n = 1'b1;
  logic [15:0] fifo_cnt = '0;
  logic        rx_rdy_n, rx_dsc_n, fifo_we, id_we, ctl_vld, ctl_first, ctl_last, hdr_err;
  logic [31:0] fifo_wd, id_wd, ctl_data;
  logic [6:0]  id_idx;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  fis_rx_split u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] d, input bit s, input bit e);
    rx_data = d; rx_sof_n = !s; rx_eof_n = !e; rx_vld_n = 1'b0;
    @(negedge clk);
    rx_vld_n = 1'b1; rx_sof_n = 1'b1; rx_eof_n = 1'b1;
  endtask

  function automatic logic [31:0] pat(input int n, input int i);
    return {n[15:0], i[15:0]} ^ 32'hA5A5_0000;
  endfunction

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_dsc_n === 1'b1, "R1 dsc", {31'd0, rx_dsc_n}, 32'd1);
    chk({fifo_we, id_we, ctl_vld, hdr_err} === 4'b0, "R1 strobes", {28'd0, fifo_we, id_we, ctl_vld, hdr_err}, 32'd0);

    // R2 threshold sweep
    mode_read = 1'b1;
    for (int c = 65500; c <= 65535; c++) begin
      fifo_cnt = c[15:0]; #1;
      chk(rx_rdy_n === (c >= 65528), "R2 rdy", {31'd0, rx_rdy_n}, {31'd0, c >= 65528});
    end
    mode_read = 1'b0; #1;
    chk(rx_rdy_n === 1'b0, "R2 rdy no read", {31'd0, rx_rdy_n}, 32'd0);
    fifo_cnt = 16'd0;

    // R3 read payload sweep
    mode_read = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      put(32'h0000_0046, 1, 0);
      chk(!fifo_we && !id_we, "R3 header not forwarded", {31'd0, fifo_we}, 32'd0);
      for (int i = 0; i < n; i++) begin
        put(pat(n, i), 0, i == n - 1);
        chk(fifo_we && fifo_wd === pat(n, i) && !id_we, "R3 payload", fifo_wd, pat(n, i));
      end
    end

    // R9 word after end without start, and idle valid-high word
    put(32'h1234_5678, 0, 0);
    chk(!fifo_we && !ctl_vld && !id_we, "R9 after eof", {31'd0, fifo_we}, 32'd0);
    rx_sof_n = 1'b0; rx_data = 32'h46; @(negedge clk); rx_sof_n = 1'b1;
    chk(!fifo_we && !ctl_vld && !hdr_err, "R9 valid high", {31'd0, ctl_vld}, 32'd0);

    // R4 stall mid frame
    put(32'h0000_0046, 1, 0);
    put(32'hCAFE_0001, 0, 0);
    chk(fifo_we && fifo_wd === 32'hCAFE_0001, "R4 before full", fifo_wd, 32'hCAFE_0001);
    fifo_cnt = 16'd65528;
    put(32'hCAFE_0002, 0, 1);
    chk(!fifo_we, "R4 refused when full", {31'd0, fifo_we}, 32'd0);
    @(negedge clk);
    chk(!fifo_we, "R4 still stopped", {31'd0, fifo_we}, 32'd0);
    fifo_cnt = 16'd65527;
    put(32'hCAFE_0002, 0, 1);
    chk(fifo_we && fifo_wd === 32'hCAFE_0002, "R4 resumed", fifo_wd, 32'hCAFE_0002);
    fifo_cnt = 16'd0;
    mode_read = 1'b0;

    // R5/R6 identify sweep
    mode_ident = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      put(32'h0000_0046, 1, 0);
      for (int i = 0; i < n; i++) begin
        put(pat(n, i), 0, i == n - 1);
        chk(id_we && id_idx === i[6:0] && id_wd === pat(n, i) && !fifo_we, "R6 ident index",
            {25'd0, id_idx}, i);
      end
    end
    mode_read = 1'b1;
    put(32'h0000_0046, 1, 0);
    for (int i = 0; i < 128; i++) begin
      put(pat(128, i), 0, i == 127);
      chk(id_we && !fifo_we && id_idx === i[6:0] && id_wd === pat(128, i), "R5 ident priority",
          {25'd0, id_idx}, i);
    end
    mode_ident = 1'b0;

    // R7 non-data frames
    put(32'h0050_0034, 1, 0);
    chk(ctl_vld && ctl_first && !ctl_last && ctl_data === 32'h0050_0034, "R7 ctl first", ctl_data, 32'h0050_0034);
    put(32'h1111_2222, 0, 0);
    chk(ctl_vld && !ctl_first && !ctl_last && ctl_data === 32'h1111_2222, "R7 ctl mid", ctl_data, 32'h1111_2222);
    put(32'h3333_4444, 0, 1);
    chk(ctl_vld && ctl_last && ctl_data === 32'h3333_4444 && !fifo_we, "R7 ctl last", ctl_data, 32'h3333_4444);
    put(32'h0000_00A1, 1, 1);
    chk(ctl_vld && ctl_first && ctl_last, "R7 ctl single", {30'd0, ctl_first, ctl_last}, 32'd3);

    // R8 bad header and unrouted data frame
    put(32'h0100_0046, 1, 0);
    chk(hdr_err && !ctl_vld, "R8 reserved bits", {31'd0, hdr_err}, 32'd1);
    put(32'hDEAD_0001, 0, 1);
    chk(!hdr_err && !fifo_we && !id_we && !ctl_vld, "R8 payload dropped", {31'd0, fifo_we}, 32'd0);
    mode_read = 1'b0;
    put(32'h0000_0046, 1, 0);
    chk(hdr_err, "R8 no mode", {31'd0, hdr_err}, 32'd1);
    put(32'hDEAD_0002, 0, 1);
    chk(!fifo_we && !id_we && !ctl_vld, "R8 no mode dropped", {31'd0, id_we}, 32'd0);
    chk(rx_dsc_n === 1'b1, "R1 dsc end", {31'd0, rx_dsc_n}, 32'd1);

    finish_run();
  end
endmodule